// File: doc/BRIEF.md
# Reload-and-Match Toggle PWM Timer

This block drives one pulse-width-modulated output from a free-running up-counter. The counter climbs from a programmable reload value to all-ones. At the all-ones value it overflows and takes the reload value again on the next tick. The output flips on every overflow and again when the counter passes the match value. The reload value therefore sets the period, and the distance from reload to match sets the active time. A polarity input inverts the output. A prescaler can slow the counting tick down to a power-of-two fraction of the clock.

Settings arrive in one of two ways, both through the same pair of argument buses. A direct write supplies the reload and match values themselves. A cycle write supplies a period and a duty in ticks, and a small converter turns them into a reload and match pair, clamping the duty into range. A write that breaks the ordering rules is dropped and raises an error flag. Each start, and each running write that changes the settings, preloads the counter to all-ones minus one. The first event is then always an overflow.

The control is a three-state machine. IDLE holds the output at its idle level and leaves the counter frozen. PRIME counts from the preload value up to the first overflow, with the match comparator disarmed. RUN counts normally and reacts to both overflow and match. Transitions: IDLE→PRIME on start; PRIME→RUN on the first overflow; PRIME→PRIME and RUN→PRIME when a valid, differing write lands while counting (restart); PRIME→IDLE and RUN→IDLE on stop.

Top module: `toggle_pwm_timer`

## Requirements
- R1: After reset the output sits at the idle level (equal to `pol_i`), `running_o` is low and `cfg_err_o` is low.
- R2: After a start pulse the counter is preloaded to all-ones minus one. The output turns active exactly two ticks after the start is sampled.
- R3: With reload L and match M, each period has an active phase of (M − L + 1) ticks and an inactive phase of (all-ones − M) ticks. After an overflow the counter holds L.
- R4: A cycle write with period P and duty D programs reload = 2^32 − P and match = reload + D − 1.
- R5: In a cycle write a duty of 0 becomes 1, and a duty of P or more becomes P − 1.
- R6: A write is rejected and leaves the settings unchanged when P < 2 (cycle write), when M equals all-ones, or when L > M (direct write). A rejected write sets `cfg_err_o`.
- R7: `pwm_o` equals the internal active level XOR `pol_i`, so the idle level is low for `pol_i`=0 and high for `pol_i`=1.
- R8: With `pre_en_i`=0 the counter advances every clock. With `pre_en_i`=1 it advances once every 2^(`pre_sel_i`+1) clocks.
- R9: A stop pulse returns the output to its idle level and clears `running_o` one clock after it is sampled.
- R10: A valid write of the values already in force while counting causes no restart and leaves the waveform undisturbed.
- R11: A valid write of different values while counting restarts through the preload. The output goes idle at once and turns active two ticks later with the new timing.
- R12: `cfg_err_o` reflects the most recent write: a valid write clears it, and it keeps its value when no write occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, taken only in IDLE |
| stop_i | input | 1 | Stop pulse, highest priority |
| wr_pair_i | input | 1 | Direct write: arg A = reload, arg B = match |
| wr_cycles_i | input | 1 | Cycle write: arg A = period, arg B = duty (wins over wr_pair_i) |
| arg_a_i | input | 32 | Reload value or period |
| arg_b_i | input | 32 | Match value or duty |
| pol_i | input | 1 | Output inversion |
| pre_en_i | input | 1 | Prescaler enable |
| pre_sel_i | input | 3 | Prescaler exponent, divide by 2^(sel+1) |
| pwm_o | output | 1 | PWM output |
| running_o | output | 1 | High in PRIME or RUN |
| cfg_err_o | output | 1 | Last write was rejected |

## Verification
The waveform is measured by its start latency and its active and inactive lengths. These are taken for a nominal duty, for duties that clamp at both ends, for the shortest legal period, for a direct pair with reload equal to match, and for several prescaler settings under both polarities. Period and clamping faults show up as wrong phase lengths, while latency and phase lengths scaled by the divisor expose a wrong preload or prescaler. Writes made while counting are placed just after the active edge. A rejected write or an identical rewrite must leave the remaining active time intact, while a changed write must drop the output at once.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PRIME = 2'd1,
        ST_RUN   = 2'd2
    } pwmt_state_e;
endpackage

// File: rtl/pwmt_cfg_calc.sv
// Converts a write request into a reload/match pair and judges its legality.
module pwmt_cfg_calc #(
    parameter int CNT_W = 32
) (
    input  logic             use_cycles,
    input  logic [CNT_W-1:0] arg_a,
    input  logic [CNT_W-1:0] arg_b,
    output logic [CNT_W-1:0] load_o,
    output logic [CNT_W-1:0] match_o,
    output logic             ok_o
);
    localparam logic [CNT_W-1:0] ALL1 = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};
    localparam logic [CNT_W-1:0] TWO  = ONE + ONE;

    logic [CNT_W-1:0] duty_fix;

    always_comb begin
        duty_fix = arg_b;
        if (arg_b == '0) begin
            duty_fix = ONE;                 // R5 lower clamp
        end else if (arg_b >= arg_a) begin
            duty_fix = arg_a - ONE;         // R5 upper clamp
        end
        if (use_cycles) begin
            load_o  = '0 - arg_a;           // R4: all-ones - P + 1
            match_o = load_o + duty_fix - ONE;
            ok_o    = (arg_a >= TWO);
        end else begin
            load_o  = arg_a;
            match_o = arg_b;
            ok_o    = (arg_a <= arg_b) && (arg_b != ALL1);
        end
    end
endmodule

// File: rtl/pwmt_prescale.sv
// Tick generator: every clock, or once per 2^(sel+1) clocks.
module pwmt_prescale #(
    parameter int PRE_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clr,
    input  logic             en,
    input  logic [PRE_W-1:0] sel,
    output logic             tick
);
    localparam int DIV_W = 1 << PRE_W;

    logic [DIV_W-1:0] div_cnt;
    logic [DIV_W-1:0] limit;

    always_comb begin
        limit = '0;
        for (int i = 0; i < DIV_W; i++) begin
            limit[i] = en && (i <= int'(sel));
        end
    end

    assign tick = run && (div_cnt == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_cnt <= '0;
        end else if (clr || !run || tick) begin
            div_cnt <= '0;
        end else begin
            div_cnt <= div_cnt + 1'b1;
        end
    end

    assert_undivided_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !en && !$past(clr) && $past(run)) |-> tick);
endmodule

// File: rtl/pwmt_core.sv
// Counter, toggle flop, held settings and the IDLE/PRIME/RUN controller.
module pwmt_core
    import pwmt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             start,
    input  logic             stop,
    input  logic             wr,
    input  logic             wr_ok,
    input  logic [CNT_W-1:0] new_load,
    input  logic [CNT_W-1:0] new_match,
    output logic             raw_o,
    output logic             running_o,
    output logic             err_o,
    output logic             restart_o
);
    localparam logic [CNT_W-1:0] ALL1    = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] PRELOAD = ALL1 - 1'b1;

    pwmt_state_e      state, nxt;
    logic [CNT_W-1:0] cnt_q, load_r, match_r;
    logic             raw_q, err_q;
    logic             apply, same, restart_cfg, go_prime, ovf;

    always_comb begin
        apply       = wr && wr_ok;
        same        = (new_load == load_r) && (new_match == match_r);
        restart_cfg = apply && !same && (state != ST_IDLE);
        go_prime    = !stop && (restart_cfg || (start && state == ST_IDLE));
        ovf         = tick && (cnt_q == ALL1);
        nxt         = state;
        unique case (state)
            ST_IDLE:  if (go_prime) nxt = ST_PRIME;
            ST_PRIME: begin
                if (stop)             nxt = ST_IDLE;
                else if (restart_cfg) nxt = ST_PRIME;
                else if (ovf)         nxt = ST_RUN;
            end
            ST_RUN: begin
                if (stop)             nxt = ST_IDLE;
                else if (restart_cfg) nxt = ST_PRIME;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Datapath and output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            load_r  <= '0;
            match_r <= '0;
            raw_q   <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            if (apply) begin
                load_r  <= new_load;
                match_r <= new_match;
            end
            if (wr) err_q <= !wr_ok;
            if (go_prime) begin
                cnt_q <= PRELOAD;
                raw_q <= 1'b0;
            end else if (stop) begin
                raw_q <= 1'b0;
            end else if (state != ST_IDLE && tick) begin
                if (cnt_q == ALL1) begin
                    cnt_q <= load_r;
                    raw_q <= ~raw_q;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                    if (state == ST_RUN && cnt_q == match_r) raw_q <= ~raw_q;
                end
            end
        end
    end

    assign raw_o     = raw_q;
    assign running_o = (state != ST_IDLE);
    assign err_o     = err_q;
    assign restart_o = go_prime;

    assert_stop_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && state != ST_IDLE) |=> (state == ST_IDLE && raw_q == 1'b0));
    assert_prime_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PRIME) |-> (cnt_q[CNT_W-1:1] == ALL1[CNT_W-1:1]));
    assert_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && ovf && !stop && !restart_cfg) |=> (cnt_q == $past(load_r)));
    assert_legal_pair_R6: assert property (@(posedge clk) disable iff (!rst_n)
        apply |-> (new_load <= new_match && new_match != ALL1));
    assert_same_no_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (apply && same && state == ST_RUN && !stop) |=> (state == ST_RUN));
    assert_restart_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (restart_cfg && !stop) |=> (state == ST_PRIME && raw_q == 1'b0 && cnt_q == PRELOAD));
endmodule

// File: rtl/toggle_pwm_timer.sv
module toggle_pwm_timer #(
    parameter int CNT_W = 32,
    parameter int PRE_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic             wr_pair_i,
    input  logic             wr_cycles_i,
    input  logic [CNT_W-1:0] arg_a_i,
    input  logic [CNT_W-1:0] arg_b_i,
    input  logic             pol_i,
    input  logic             pre_en_i,
    input  logic [PRE_W-1:0] pre_sel_i,
    output logic             pwm_o,
    output logic             running_o,
    output logic             cfg_err_o
);
    logic [CNT_W-1:0] calc_load, calc_match;
    logic             calc_ok, tick, raw, restart, run;

    pwmt_cfg_calc #(.CNT_W(CNT_W)) u_calc (
        .use_cycles (wr_cycles_i),
        .arg_a      (arg_a_i),
        .arg_b      (arg_b_i),
        .load_o     (calc_load),
        .match_o    (calc_match),
        .ok_o       (calc_ok)
    );

    pwmt_prescale #(.PRE_W(PRE_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .clr   (restart),
        .en    (pre_en_i),
        .sel   (pre_sel_i),
        .tick  (tick)
    );

    pwmt_core #(.CNT_W(CNT_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .start     (start_i),
        .stop      (stop_i),
        .wr        (wr_pair_i | wr_cycles_i),
        .wr_ok     (calc_ok),
        .new_load  (calc_load),
        .new_match (calc_match),
        .raw_o     (raw),
        .running_o (run),
        .err_o     (cfg_err_o),
        .restart_o (restart)
    );

    assign pwm_o     = raw ^ pol_i;   // R7
    assign running_o = run;
endmodule

// File: tb/toggle_pwm_timer_tb_top.sv
`timescale 1ns/1ps
module toggle_pwm_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0, stop_i = 1'b0, wr_pair_i = 1'b0, wr_cycles_i = 1'b0;
    logic [31:0] arg_a_i = '0, arg_b_i = '0;
    logic        pol_i = 1'b0, pre_en_i = 1'b0;
    logic [2:0]  pre_sel_i = '0;
    logic        pwm_o, running_o, cfg_err_o;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    toggle_pwm_timer dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
        .wr_pair_i(wr_pair_i), .wr_cycles_i(wr_cycles_i),
        .arg_a_i(arg_a_i), .arg_b_i(arg_b_i), .pol_i(pol_i),
        .pre_en_i(pre_en_i), .pre_sel_i(pre_sel_i),
        .pwm_o(pwm_o), .running_o(running_o), .cfg_err_o(cfg_err_o)
    );

    typedef struct packed {
        bit        cyc;
        bit [31:0] a;
        bit [31:0] b;
        bit        pen;
        bit [2:0]  psel;
        bit        pol;
        bit [15:0] hi;   // active ticks
        bit [15:0] lo;   // inactive ticks
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 32'd10, 32'd3, 1'b0, 3'd0, 1'b0, 16'd3, 16'd7},
        '{1'b1, 32'd10, 32'd0, 1'b0, 3'd0, 1'b0, 16'd1, 16'd9},
        '{1'b1, 32'd10, 32'd15, 1'b0, 3'd0, 1'b0, 16'd9, 16'd1},
        '{1'b1, 32'd2, 32'd1, 1'b0, 3'd0, 1'b0, 16'd1, 16'd1},
        '{1'b0, 32'hFFFF_FFF0, 32'hFFFF_FFF4, 1'b0, 3'd0, 1'b0, 16'd5, 16'd11},
        '{1'b1, 32'd6, 32'd2, 1'b1, 3'd0, 1'b1, 16'd2, 16'd4},
        '{1'b1, 32'd4, 32'd1, 1'b1, 3'd2, 1'b0, 16'd1, 16'd3},
        '{1'b0, 32'hFFFF_FFFA, 32'hFFFF_FFFA, 1'b0, 3'd0, 1'b1, 16'd1, 16'd5}
    };

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    task automatic write_cfg(input bit cyc, input logic [31:0] a, input logic [31:0] b);
        arg_a_i = a; arg_b_i = b;
        wr_cycles_i = cyc; wr_pair_i = !cyc;
        @(negedge clk);
        wr_cycles_i = 1'b0; wr_pair_i = 1'b0;
    endtask

    task automatic pulse_start();
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic pulse_stop();
        stop_i = 1'b1;
        @(negedge clk);
        stop_i = 1'b0;
    endtask

    task automatic wait_active(output int n);
        n = 0;
        while (pwm_o == pol_i && n < 100000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic count_lvl(input bit want_active, output int n);
        n = 0;
        while (((pwm_o != pol_i) == want_active) && n < 100000) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        #2_000_000;
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int lat, hi, lo;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 pwm idle", pwm_o, 0);
        chk("R1 running", running_o, 0);
        chk("R1 err", cfg_err_o, 0);

        // Table walk: R2/R3/R4/R5/R7/R8
        for (int v = 0; v < NV; v++) begin
            int div;
            div = VEC[v].pen ? (1 << (VEC[v].psel + 1)) : 1;
            pulse_stop();
            pol_i = VEC[v].pol; pre_en_i = VEC[v].pen; pre_sel_i = VEC[v].psel;
            write_cfg(VEC[v].cyc, VEC[v].a, VEC[v].b);
            chk("R12 valid write err", cfg_err_o, 0);
            pulse_start();
            wait_active(lat);
            chk("R2/R8 start latency", lat, 2 * div);
            count_lvl(1'b1, hi);
            chk("R3/R4/R5/R7/R8 active", hi, VEC[v].hi * div);
            count_lvl(1'b0, lo);
            chk("R3/R4/R5/R7/R8 inactive", lo, VEC[v].lo * div);
        end

        // R9 stop
        pulse_stop();
        chk("R9 running after stop", running_o, 0);
        chk("R9 idle after stop", pwm_o, pol_i);
        // R7 idle levels
        pol_i = 1'b0; #1;
        chk("R7 idle low", pwm_o, 0);
        pol_i = 1'b1; #1;
        chk("R7 idle high", pwm_o, 1);
        pol_i = 1'b0; pre_en_i = 1'b0;
        @(negedge clk);

        // R6 rejected writes leave settings intact
        write_cfg(1'b1, 32'd10, 32'd3);
        write_cfg(1'b1, 32'd1, 32'd1);
        chk("R6 short period err", cfg_err_o, 1);
        write_cfg(1'b0, 32'hFFFF_FFF0, 32'hFFFF_FFFF);
        chk("R6 match all-ones err", cfg_err_o, 1);
        write_cfg(1'b0, 32'hFFFF_FFF8, 32'hFFFF_FFF4);
        chk("R6 load above match err", cfg_err_o, 1);
        @(negedge clk);
        chk("R12 err holds", cfg_err_o, 1);
        pulse_start();
        wait_active(lat);
        count_lvl(1'b1, hi);
        chk("R6 settings kept active", hi, 3);
        count_lvl(1'b0, lo);
        chk("R6 settings kept inactive", lo, 7);

        // R6 rejected write while running
        wait_active(lat);
        write_cfg(1'b1, 32'd0, 32'd0);
        count_lvl(1'b1, hi);
        chk("R6 running reject undisturbed", hi, 2);

        // R10 identical rewrite while running
        wait_active(lat);
        write_cfg(1'b1, 32'd10, 32'd3);
        chk("R12 err cleared", cfg_err_o, 0);
        count_lvl(1'b1, hi);
        chk("R10 rewrite undisturbed", hi, 2);
        chk("R10 still running", running_o, 1);

        // R11 differing write while running
        wait_active(lat);
        write_cfg(1'b1, 32'd8, 32'd5);
        chk("R11 output idle after change", pwm_o, pol_i);
        wait_active(lat);
        chk("R11 restart latency", lat, 2);
        count_lvl(1'b1, hi);
        chk("R11/R4 new active", hi, 5);
        count_lvl(1'b0, lo);
        chk("R11/R4 new inactive", lo, 3);

        finish_run();
    end
endmodule